// File: doc/BRIEF.md
# Paired-Bit Array Multiplier

This block multiplies an unsigned `YW`-bit operand by an unsigned `XW`-bit operand and returns the full-width product. It does not build one adder row per multiplier bit. Each adder row takes two multiplier bits together and forms `(2*x_hi + x_lo) * Y` in a single ripple of fused cells. Each cell XORs two AND terms with an incoming carry, and its carry-out is the majority of those three signals. The number of rows is therefore half the multiplier width.

The row results sit at weights that step by a factor of four. A ripple adder chain sums them into the product. An odd multiplier width is handled by padding the multiplier with a zero bit at the top. A parameter selects one of two output forms: a synchronously reset output register, which gives a latency of one cycle, or a purely combinational output.

Top module: `paired_bit_mult`

## Requirements
- R1: `prod` equals `op_y * op_x` as unsigned integers over its full `YW+XW` bits, with no truncation.
- R2: Every internal row value equals `(2*x[2r+1] + x[2r]) * op_y` and fits in `YW+2` bits. The operand terms below bit 0 and above bit `YW-1` of `op_y` count as zero, and the carry into the lowest cell of each row is zero.
- R3: With an odd `XW`, the multiplier is padded with one zero bit at the top, and the product is still exact.
- R4: When either operand is zero, the product is zero.
- R5: When both operands are all ones, the product is `(2^YW-1)*(2^XW-1)`.
- R6: With `OUT_REG=1`, `prod` shows the product of the operands sampled at the previous rising clock edge and holds that value until the next edge. While `rst_n` is low at an edge, `prod` becomes zero.
- R7: With `OUT_REG=0`, `prod` follows the operands combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_y | input | YW | Multiplicand |
| op_x | input | XW | Multiplier, consumed two bits per row |
| prod | output | YW+XW | Unsigned product |

## Verification
The bench builds two copies of the block. The first uses `YW=8`, `XW=8` and `OUT_REG=1`; it covers the registered latency, the reset behaviour and four full rows, including the final carry out of the top row. The second uses `YW=8`, `XW=5` and `OUT_REG=0`; its odd width forces the zero-padded top row and the combinational path. With these widths, the all-ones and single-top-bit operand patterns reach the highest product bits in both copies.

// File: rtl/paired_bit_mult.sv
module paired_bit_mult #(
  parameter int YW      = 8,
  parameter int XW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [YW-1:0]     op_y,
  input  logic [XW-1:0]     op_x,
  output logic [YW+XW-1:0]  prod
);
  localparam int XE = XW + (XW % 2);
  localparam int NR = XE / 2;
  localparam int RW = YW + 2;
  localparam int PW = YW + XW;
  localparam int AW = YW + XE;

  logic [XE-1:0]            xe;
  logic [RW-1:0]            ye;
  logic [NR-1:0][RW-1:0]    row_val;
  logic [NR-1:0][YW+1:0]    cy;
  logic [NR:0][AW-1:0]      acc;
  logic [PW-1:0]            prod_c;

  assign xe     = XE'(op_x);
  assign ye     = {1'b0, op_y, 1'b0};
  assign acc[0] = '0;

  for (genvar r = 0; r < NR; r++) begin : g_row
    assign cy[r][0] = 1'b0;
    for (genvar j = 0; j <= YW; j++) begin : g_cell
      logic t_lo, t_hi;
      assign t_lo = xe[2*r]   & ye[j+1];
      assign t_hi = xe[2*r+1] & ye[j];
      assign row_val[r][j] = t_lo ^ t_hi ^ cy[r][j];
      assign cy[r][j+1]    = (t_lo & t_hi) | (t_lo & cy[r][j]) | (t_hi & cy[r][j]);
    end
    assign row_val[r][RW-1] = cy[r][YW+1];
    assign acc[r+1] = acc[r] + (AW'(row_val[r]) << (2*r));
  end

  assign prod_c = acc[NR][PW-1:0];

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) prod <= '0;
      else        prod <= prod_c;
    end
  end else begin : g_comb
    assign prod = prod_c;
  end
endmodule

// File: rtl/paired_mult_chk.sv
module paired_mult_chk #(
  parameter int YW      = 8,
  parameter int XW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic [YW-1:0]                        op_y,
  input logic [XW-1:0]                        op_x,
  input logic [YW+XW-1:0]                     prod,
  input logic [(XW+(XW%2))/2-1:0][YW+1:0]     row_val
);
  localparam int XE = XW + (XW % 2);
  localparam int NR = XE / 2;
  localparam int PW = YW + XW;
  localparam int RW = YW + 2;

  logic [XE-1:0] xe;
  logic [PW-1:0] ref_p;
  logic          seen;

  assign xe    = XE'(op_x);
  assign ref_p = PW'(op_y) * PW'(op_x);

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  for (genvar r = 0; r < NR; r++) begin : g_rowchk
    p_row_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
      row_val[r] == RW'(RW'(op_y) * RW'(xe[2*r +: 2])));
  end

  if (OUT_REG) begin : g_seq
    p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> prod == $past(ref_p));
    p_zero_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_x == '0 || op_y == '0) |=> prod == '0);
    p_all_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (&op_x && &op_y) |=> prod == PW'({YW{1'b1}}) * PW'({XW{1'b1}}));
    p_reg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> $stable(prod) || prod == $past(ref_p));
  end else begin : g_cmb
    p_product_r7: assert property (@(posedge clk) disable iff (!rst_n)
      prod == ref_p);
    p_zero_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_x == '0 || op_y == '0) |-> prod == '0);
    p_all_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (&op_x && &op_y) |-> prod == PW'({YW{1'b1}}) * PW'({XW{1'b1}}));
  end
endmodule

bind paired_bit_mult paired_mult_chk #(.YW(YW), .XW(XW), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_y(op_y), .op_x(op_x), .prod(prod), .row_val(row_val)
);

// File: tb/paired_bit_mult_test.sv
module paired_bit_mult_test;
  localparam int CLK_NS = 10;
  localparam int NV     = 12;
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'h00, 16'h0000},
    {8'hFF, 8'hFF, 16'hFE01},
    {8'h01, 8'hFF, 16'h00FF},
    {8'hFF, 8'h01, 16'h00FF},
    {8'h80, 8'h80, 16'h4000},
    {8'h0F, 8'h0F, 16'h00E1},
    {8'h12, 8'h34, 16'h03A8},
    {8'hAA, 8'h55, 16'h3872},
    {8'h03, 8'h02, 16'h0006},
    {8'hC8, 8'h64, 16'h4E20},
    {8'h7F, 8'h81, 16'h3FFF},
    {8'hFE, 8'h02, 16'h01FC}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  y8 = '0, x8 = '0;
  logic [15:0] p8;
  logic [7:0]  yo = '0;
  logic [4:0]  xo = '0;
  logic [12:0] po;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  paired_bit_mult #(.YW(8), .XW(8), .OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .op_y(y8), .op_x(x8), .prod(p8));
  paired_bit_mult #(.YW(8), .XW(5), .OUT_REG(1'b0)) uut_odd (
    .clk(clk), .rst_n(rst_n), .op_y(yo), .op_x(xo), .prod(po));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply8(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    y8 = a; x8 = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R6: reset clears the register even with nonzero operands
    y8 = 8'hFF; x8 = 8'hFF;
    repeat (2) @(posedge clk);
    #1;
    check("R6 reset", p8, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R4 R5: vector table
    for (int i = 0; i < NV; i++) begin
      apply8(VEC[i][31:24], VEC[i][23:16]);
      if (VEC[i][31:24] == 8'h00 || VEC[i][23:16] == 8'h00)
        check("R4 zero operand", p8, VEC[i][15:0]);
      else if (VEC[i][31:24] == 8'hFF && VEC[i][23:16] == 8'hFF)
        check("R5 all ones", p8, VEC[i][15:0]);
      else
        check("R1 table", p8, VEC[i][15:0]);
    end

    // R6: one-cycle latency and hold
    apply8(8'h10, 8'h10);
    @(negedge clk);
    y8 = 8'h05; x8 = 8'h07;
    #1;
    check("R6 hold before edge", p8, 16'h0100);
    @(posedge clk); #1;
    check("R6 update after edge", p8, 16'd35);

    // R1: random operands, reference from the bench's own multiply
    for (int i = 0; i < 200; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom); b = 8'($urandom);
      apply8(a, b);
      check("R1 random", p8, 16'(a) * 16'(b));
    end

    // R4: zero on one side only
    apply8(8'h00, 8'hA7);
    check("R4 zero y", p8, 16'h0000);
    apply8(8'h5C, 8'h00);
    check("R4 zero x", p8, 16'h0000);

    // R6: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R6 mid reset", p8, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // R3 R7: odd multiplier width, combinational output
    yo = 8'hFF; xo = 5'h1F; #1;
    check("R5 odd all ones", 16'(po), 16'd7905);
    yo = 8'h00; xo = 5'h13; #1;
    check("R4 odd zero", 16'(po), 16'h0000);
    yo = 8'h9B; xo = 5'h10; #1;
    check("R3 odd top bit", 16'(po), 16'd2480);
    for (int i = 0; i < 200; i++) begin
      logic [7:0] a;
      logic [4:0] b;
      a = 8'($urandom); b = 5'($urandom);
      yo = a; xo = b; #1;
      check("R7 comb random", 16'(po), 16'(a) * 16'(b));
      @(negedge clk);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule